// File: doc/BRIEF.md
# Clocked Serial I/O Transceiver

A byte-wide synchronous serial port that sits behind a two-location CPU register window. One location is a shared data buffer: a CPU write provides the next byte to send, and a CPU read returns the most recently received byte. The other location holds the control bits (run, abort, clock source) and, when read, reports the busy and interrupt-pending flags. Every transfer shifts 8 bits out and 8 bits in at the same time, least-significant bit first. The outgoing bit changes on the falling edge of the serial clock, and the incoming bit is sampled on the rising edge.

The serial clock can be generated internally by dividing the system clock, or taken from an external pin. In internal mode the port stops its clock after each byte. It resumes on its own once the CPU has read the received byte and written a new one. In external mode the port follows the incoming edges without waiting. If the CPU does not supply a new byte in time, the next byte sent is the one just received. Clearing the run bit stops the port after the current byte. Setting the abort bit stops it at once.

Top module: `csio_xcvr`

## Requirements
- R1: The data output changes only on a falling serial clock edge, and the data input is sampled on a rising edge. Bits are sent and received least-significant first.
- R2: After the 8th rising edge of a byte, the received byte is stored in the buffer, the interrupt-pending flag (status bit 4) is set, and `irq_o` goes high.
- R3: A write to address 0 supplies the next transmit byte. A read of address 0 returns the last received byte.
- R4: Writing run (control bit 0) begins a transfer and raises `busy_o` (status bit 3) only once a transmit byte has been written. Without one, the port stays idle.
- R5: In internal mode, after a byte completes with run still set, the serial clock stays high and `busy_o` stays high until the buffer has been read and then written. The next byte then starts without any further command.
- R6: With the external clock (control bit 2 set), the port drives no clock and shifts only on the synchronized edges of `sck_i`. It continues into the next byte without waiting. If no new byte was written, it resends the byte it just received.
- R7: From the start of a transfer until its first falling edge, `so_o` keeps the last bit sent by the previous transfer (0 after reset).
- R8: Clearing run during a byte lets that byte complete and be stored. `busy_o` then drops.
- R9: Writing abort (control bit 1) ends the transfer on the next clock edge. `busy_o` drops, `sck_o` returns high, run clears, and the partial byte is not stored.
- R10: A control write that changes the clock-source bit clears the buffer to zero.
- R11: A read of address 0 or a write of address 0 clears the interrupt-pending flag.
- R12: The internal serial clock idles high, and each of its half periods lasts `HALF_DIV` system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | CPU write strobe |
| rd_en | input | 1 | CPU read strobe (read side effects) |
| addr | input | 1 | 0 = data buffer, 1 = control/status |
| wdata | input | DW | CPU write data |
| rdata | output | DW | CPU read data (combinational from `addr`) |
| sck_o | output | 1 | Generated serial clock, high when idle |
| sck_i | input | 1 | External serial clock |
| so_o | output | 1 | Serial data out |
| si_i | input | 1 | Serial data in |
| irq_o | output | 1 | Interrupt request, follows the pending flag |
| busy_o | output | 1 | Transfer in progress |

## Verification
The assertions assume that a CPU buffer access never falls in the same cycle as a byte completion. They also assume that the clock-source bit is never changed while the port is busy, and that the external clock's half period is well above the synchronizer latency. The stimulus meets these conditions by touching the buffer only after the interrupt has been seen, or while the port is idle. The external clock is driven with 8-cycle half periods, and `si_i` is changed just after each observed falling edge, so it is stable long before the synchronized rising edge samples it.

// File: rtl/csio_pkg.sv
package csio_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } csio_state_e;

  localparam int CTL_GO   = 0;
  localparam int CTL_HALT = 1;
  localparam int CTL_EXT  = 2;
  localparam int STS_BUSY = 3;
  localparam int STS_IRQ  = 4;

  localparam logic ADDR_DATA = 1'b0;
  localparam logic ADDR_CTRL = 1'b1;
endpackage

// File: rtl/csio_sync.sv
module csio_sync #(
  parameter int W = 2,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  localparam int CHAIN_W = STAGES * W;

  logic [CHAIN_W-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= {chain_q[CHAIN_W-W-1:0], d_i};
  end

  assign q_o = chain_q[CHAIN_W-1 -: W];
endmodule

// File: rtl/csio_clkgen.sv
module csio_clkgen #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic ext_i,
  input  logic sck_s_i,
  output logic sck_o,
  output logic fall_o,
  output logic rise_o
);
  localparam int DCW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  function automatic logic half_hit(input logic [DCW-1:0] c);
    return c == DCW'(HALF_DIV - 1);
  endfunction

  logic [DCW-1:0] div_q;
  logic           sck_q;
  logic           last_q;
  logic           run_int;
  logic           tick;
  logic           ext_fall;
  logic           ext_rise;

  assign run_int = active_i && !ext_i;
  assign tick    = run_int && half_hit(div_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      sck_q <= 1'b1;
    end else if (!run_int) begin
      div_q <= '0;
      sck_q <= 1'b1;
    end else if (tick) begin
      div_q <= '0;
      sck_q <= !sck_q;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b1;
    else        last_q <= sck_s_i;
  end

  assign ext_fall = last_q && !sck_s_i;
  assign ext_rise = !last_q && sck_s_i;

  assign fall_o = ext_i ? (active_i && ext_fall) : (tick && sck_q);
  assign rise_o = ext_i ? (active_i && ext_rise) : (tick && !sck_q);
  assign sck_o  = sck_q;

  a_r12_clock_idles_high: assert property (@(posedge clk) disable iff (!rst_n)
    !(active_i && !ext_i) |=> sck_o);
  a_r1_edges_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(fall_o && rise_o));
endmodule

// File: rtl/csio_shifter.sv
module csio_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fall_i,
  input  logic          rise_i,
  input  logic          abort_i,
  input  logic          use_buf_i,
  input  logic [DW-1:0] buf_i,
  input  logic          si_i,
  output logic          so_o,
  output logic          first_o,
  output logic          done_o,
  output logic [DW-1:0] rx_o
);
  localparam int CW = (DW > 1) ? $clog2(DW) : 1;

  function automatic logic [DW-1:0] shift_in(input logic [DW-1:0] sh, input logic b);
    return {b, sh[DW-1:1]};
  endfunction

  logic [DW-1:0] sh_q;
  logic [CW-1:0] cnt_q;
  logic          so_q;
  logic [DW-1:0] src;

  assign first_o = fall_i && (cnt_q == '0);
  assign src     = (first_o && use_buf_i) ? buf_i : sh_q;
  assign done_o  = rise_i && (cnt_q == CW'(DW - 1));
  assign rx_o    = shift_in(sh_q, si_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      so_q  <= 1'b0;
    end else if (abort_i) begin
      cnt_q <= '0;
    end else begin
      if (fall_i) begin
        sh_q <= src;
        so_q <= src[0];
      end
      if (rise_i) begin
        sh_q  <= rx_o;
        cnt_q <= done_o ? '0 : cnt_q + 1'b1;
      end
    end
  end

  assign so_o = so_q;

  a_r1_so_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_i |=> $stable(so_o));
endmodule

// File: rtl/csio_xcvr.sv
module csio_xcvr
  import csio_pkg::*;
#(
  parameter int DW = 8,
  parameter int HALF_DIV = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          sck_o,
  input  logic          sck_i,
  output logic          so_o,
  input  logic          si_i,
  output logic          irq_o,
  output logic          busy_o
);
  csio_state_e   state_q, state_d;
  logic [DW-1:0] dbuf_q;
  logic          tx_full_q, rx_unread_q, irq_q, go_q, ext_q;

  logic          wr_data, wr_ctrl, rd_data, halt_req, mode_flip, active;
  logic          ev_fall, ev_rise, byte_first, byte_done;
  logic [DW-1:0] rx_byte;
  logic [1:0]    pins_s;

  assign wr_data   = wr_en && (addr == ADDR_DATA);
  assign wr_ctrl   = wr_en && (addr == ADDR_CTRL);
  assign rd_data   = rd_en && (addr == ADDR_DATA);
  assign halt_req  = wr_ctrl && wdata[CTL_HALT];
  assign mode_flip = wr_ctrl && (wdata[CTL_EXT] != ext_q);
  assign active    = (state_q == ST_RUN) && !halt_req;

  csio_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b01)) sync_i (
    .clk(clk), .rst_n(rst_n), .d_i({si_i, sck_i}), .q_o(pins_s)
  );

  csio_clkgen #(.HALF_DIV(HALF_DIV)) clkgen_i (
    .clk(clk), .rst_n(rst_n), .active_i(active), .ext_i(ext_q),
    .sck_s_i(pins_s[0]), .sck_o(sck_o), .fall_o(ev_fall), .rise_o(ev_rise)
  );

  csio_shifter #(.DW(DW)) shifter_i (
    .clk(clk), .rst_n(rst_n), .fall_i(ev_fall), .rise_i(ev_rise),
    .abort_i(halt_req), .use_buf_i(tx_full_q), .buf_i(dbuf_q),
    .si_i(pins_s[1]), .so_o(so_o), .first_o(byte_first),
    .done_o(byte_done), .rx_o(rx_byte)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (go_q && tx_full_q && !halt_req) state_d = ST_RUN;
      ST_RUN: begin
        if (halt_req)       state_d = ST_IDLE;
        else if (byte_done) state_d = !go_q ? ST_IDLE : (ext_q ? ST_RUN : ST_HOLD);
      end
      ST_HOLD: begin
        if (halt_req || !go_q)             state_d = ST_IDLE;
        else if (!rx_unread_q && tx_full_q) state_d = ST_RUN;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      dbuf_q      <= '0;
      tx_full_q   <= 1'b0;
      rx_unread_q <= 1'b0;
      irq_q       <= 1'b0;
      go_q        <= 1'b0;
      ext_q       <= 1'b0;
    end else begin
      state_q <= state_d;
      if (byte_first && tx_full_q) tx_full_q <= 1'b0;
      if (wr_ctrl) begin
        ext_q <= wdata[CTL_EXT];
        go_q  <= wdata[CTL_GO] && !wdata[CTL_HALT];
      end
      if (mode_flip) begin
        dbuf_q      <= '0;
        tx_full_q   <= 1'b0;
        rx_unread_q <= 1'b0;
      end
      if (wr_data) begin
        dbuf_q    <= wdata;
        tx_full_q <= 1'b1;
        irq_q     <= 1'b0;
      end
      if (rd_data) begin
        rx_unread_q <= 1'b0;
        irq_q       <= 1'b0;
      end
      if (byte_done && !halt_req) begin
        dbuf_q      <= rx_byte;
        rx_unread_q <= 1'b1;
        irq_q       <= 1'b1;
      end
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign irq_o  = irq_q;

  always_comb begin
    rdata = '0;
    if (addr == ADDR_CTRL) begin
      rdata[CTL_GO]   = go_q;
      rdata[CTL_EXT]  = ext_q;
      rdata[STS_BUSY] = busy_o;
      rdata[STS_IRQ]  = irq_q;
    end else begin
      rdata = dbuf_q;
    end
  end

  a_r9_halt_idles: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |=> (!busy_o && sck_o));
  a_r2_done_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !halt_req) |=> irq_o);
  a_r11_access_clears_irq: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_data || rd_data) && !byte_done) |=> !irq_o);
  a_r5_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD) |-> (sck_o && !ev_fall && !ev_rise));
  a_r4_start_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(tx_full_q && go_q));
  a_r8_stop_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_RUN) && !go_q && byte_done && !halt_req) |=> !busy_o);
endmodule

// File: tb/csio_xcvr_tb_top.sv
module csio_xcvr_tb_top;
  localparam int DW = 8;
  localparam int HALF = 4;
  localparam logic [7:0] GO = 8'h01, HALT = 8'h02, EXT = 8'h04;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic sck_o, so_o, irq_o, busy_o;
  logic sck_i = 1'b1, si_i = 1'b0;

  csio_xcvr #(.DW(DW), .HALF_DIV(HALF), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .sck_o(sck_o), .sck_i(sck_i),
    .so_o(so_o), .si_i(si_i), .irq_o(irq_o), .busy_o(busy_o)
  );

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0] so_q[$];
  logic [7:0] si_q[$];
  bit mon_en = 0, ext_tb = 0;
  int cyc = 0;
  int sck_edges = 0, half_seen = 0, last_edge = 0;

  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // serial-side monitor and scoreboard
  logic prev_line = 1'b1, prev_sck = 1'b1, line;
  int bidx = 0;
  logic [7:0] cap = 8'h00, scur = 8'h00, exp_b;
  always @(negedge clk) begin
    if (sck_o != prev_sck) begin
      sck_edges++;
      if (sck_o) half_seen = cyc - last_edge;
      last_edge = cyc;
    end
    prev_sck = sck_o;
    line = ext_tb ? sck_i : sck_o;
    if (!mon_en) begin
      bidx = 0;
    end else if (prev_line && !line) begin
      if (bidx == 0) scur = (si_q.size() > 0) ? si_q.pop_front() : 8'h00;
      si_i = scur[bidx];
    end else if (!prev_line && line) begin
      cap[bidx] = so_o;
      bidx++;
      if (bidx == DW) begin
        bidx = 0;
        exp_b = (so_q.size() > 0) ? so_q.pop_front() : 8'hxx;
        chk(cap === exp_b, "R1 R3 serial byte out", cap, exp_b);
      end
    end
    prev_line = line;
  end

  task automatic cpu_wr(input logic a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic cpu_rd(input logic a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic send(input logic [7:0] tx, input logic [7:0] rx);
    so_q.push_back(tx);
    si_q.push_back(rx);
    cpu_wr(1'b0, tx);
  endtask

  task automatic read_rx(input logic [7:0] e, input string tag);
    logic [7:0] d;
    cpu_rd(1'b0, d);
    chk(d == e, tag, d, e);
  endtask

  task automatic wait_irq(input string tag);
    int n = 0;
    while (!irq_o && n < 3000) begin @(negedge clk); n++; end
    chk(irq_o == 1'b1, tag, irq_o, 1);
  endtask

  task automatic ext_byte();
    for (int i = 0; i < DW; i++) begin
      @(posedge clk); sck_i <= 1'b0;
      repeat (8) @(posedge clk);
      sck_i <= 1'b1;
      repeat (8) @(posedge clk);
    end
    repeat (6) @(posedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    int e0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy_o == 0, "reset busy", busy_o, 0);
    chk(irq_o == 0, "reset irq", irq_o, 0);
    chk(sck_o == 1, "R12 reset clock high", sck_o, 1);
    chk(so_o == 0, "R7 reset data out", so_o, 0);
    cpu_rd(1'b1, d);
    chk(d == 0, "reset status", d, 0);
    mon_en = 1;

    // R4: run without data stays idle
    cpu_wr(1'b1, GO);
    repeat (20) @(negedge clk);
    chk(busy_o == 0, "R4 idle without data", busy_o, 0);
    chk(sck_edges == 0, "R4 no clock without data", sck_edges, 0);
    send(8'hA5, 8'h3C);
    @(negedge clk);
    chk(busy_o == 1, "R4 busy once data written", busy_o, 1);

    // R2/R5/R12: first byte, then hold
    wait_irq("R2 irq after first byte");
    cpu_rd(1'b1, d);
    chk(d[4] == 1, "R2 pending flag in status", d[4], 1);
    chk(busy_o == 1, "R5 busy while held", busy_o, 1);
    chk(half_seen == HALF, "R12 half period", half_seen, HALF);
    e0 = sck_edges;
    repeat (30) @(negedge clk);
    chk(sck_edges == e0, "R5 clock held after byte", sck_edges, e0);
    read_rx(8'h3C, "R3 read returns received byte");
    chk(irq_o == 0, "R11 read clears irq", irq_o, 0);
    repeat (20) @(negedge clk);
    chk(sck_edges == e0, "R5 held until write", sck_edges, e0);

    // R7: resume, output holds last bit (A5 bit7 = 1) before first fall
    send(8'h5A, 8'hC3);
    chk(so_o == 1, "R7 holds previous last bit", so_o, 1);
    repeat (2) @(negedge clk);
    chk(so_o == 1 && sck_o == 1 && busy_o == 1, "R7 hold before first fall", {so_o, sck_o, busy_o}, 3'b111);
    wait_irq("R5 auto resume completes");
    read_rx(8'hC3, "R3 second received byte");

    // R8: graceful stop
    send(8'hFF, 8'h0F);
    repeat (10) @(negedge clk);
    cpu_wr(1'b1, 8'h00);
    chk(busy_o == 1, "R8 byte continues after stop", busy_o, 1);
    wait_irq("R8 byte completes after stop");
    @(negedge clk);
    chk(busy_o == 0, "R8 busy drops after byte", busy_o, 0);
    read_rx(8'h0F, "R8 stopped byte stored");

    // R9: abort
    mon_en = 0;
    cpu_wr(1'b0, 8'h11);
    cpu_wr(1'b1, GO);
    repeat (10) @(negedge clk);
    chk(busy_o == 1, "R9 transfer running", busy_o, 1);
    cpu_wr(1'b1, HALT);
    chk(busy_o == 0 && sck_o == 1, "R9 abort immediate", {busy_o, sck_o}, 2'b01);
    cpu_rd(1'b1, d);
    chk(d == 0, "R9 run bit cleared", d, 0);
    repeat (100) @(negedge clk);
    chk(irq_o == 0, "R9 partial byte not stored", irq_o, 0);

    // R10: mode change clears buffer
    cpu_wr(1'b0, 8'h77);
    cpu_wr(1'b1, EXT);
    cpu_rd(1'b0, d);
    chk(d == 0, "R10 buffer cleared by mode change", d, 0);

    // R6: external clock
    ext_tb = 1;
    mon_en = 1;
    send(8'h96, 8'h81);
    cpu_wr(1'b1, GO | EXT);
    repeat (10) @(negedge clk);
    chk(sck_o == 1 && busy_o == 1, "R6 no generated clock", {sck_o, busy_o}, 2'b11);
    ext_byte();
    wait_irq("R6 external byte completes");
    send(8'h3E, 8'h24);
    chk(irq_o == 0, "R11 write clears irq", irq_o, 0);
    ext_byte();
    wait_irq("R6 second external byte");
    so_q.push_back(8'h24);
    si_q.push_back(8'hE7);
    ext_byte();
    chk(busy_o == 1, "R6 continues without wait", busy_o, 1);
    read_rx(8'hE7, "R6 overrun byte received");
    cpu_wr(1'b1, HALT | EXT);
    chk(busy_o == 0, "R9 abort in external mode", busy_o, 0);
    chk(so_q.size() == 0, "R1 all serial bytes seen", so_q.size(), 0);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule